// File: doc/BRIEF.md
# Thread Interrupt Context Register Window

This block holds the interrupt management context of one hardware thread. The context is split into four 16-byte rings: ring 0 for user state, ring 1 for the OS, ring 2 for the hypervisor pool and ring 3 for the physical thread. Software reaches the context through a window of four pages. Every page shows the same registers, but each page has a different privilege level. Page 0 (hardware) is the most privileged, then page 1 (hypervisor), page 2 (OS) and page 3 (user). A less privileged page sees fewer rings.

Each access carries a page number, a byte offset into the context and a size code. The block checks the alignment and the privilege, then reads or writes 1, 2, 4 or 8 bytes. Reads return data in the same cycle. Writes take effect at the next clock edge.

In every ring, byte 0 is a pending-priority bitmap and byte 1 is the current priority. When any ring has a pending priority that is more favoured than its current priority, the exception output goes high. The block also packs a target block number and a target index into one identification line.

Top module: `tctx_window`

## Requirements
- R1: After reset, every context byte reads 0x00, except byte 1 of each ring, which reads 0xFF. The exception output `irq_o` is low.
- R2: The access address is {page[7:6], ring[5:4], byte[3:0]}. Bits 5:0 form the byte offset into the 64-byte context.
- R3: An access from page p may reach ring r only when r + p <= 3. Page 0 reaches every ring, and page 3 reaches only ring 0.
- R4: A read of a ring that the page may not reach returns zero. A write to such a ring leaves the context unchanged.
- R5: Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Bits [8k+7:8k] of `wdata_i` and `rdata_o` carry the byte at offset + k. Read bits above the access width are zero, and `rdata_o` is zero when there is no read request.
- R6: An access whose offset is not a multiple of its size is ignored. Such a read returns all ones, and such a write changes nothing.
- R7: A write to byte 1 of a ring (the current priority) stores 0xFF for any value from 0x08 to 0xFE. Values 0x00 to 0x07 and 0xFF are stored unchanged. This also applies inside multi-byte writes.
- R8: Byte 0 of a ring is the pending bitmap, where bit p set means priority p is pending. The best pending priority is the lowest set bit index, or 0xFF when no bit is set.
- R9: `irq_o` is high, in the same cycle as the context state, exactly when some ring's best pending priority is numerically lower than that ring's current priority.
- R10: `cam_o` equals (`blk_i` << 19) | `idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | {page, ring, byte} |
| size_i | input | 2 | Size code, 0..3 = 1, 2, 4 or 8 bytes |
| wdata_i | input | 64 | Write data, little-endian byte lanes |
| rdata_o | output | 64 | Read data, combinational |
| blk_i | input | 4 | Target block number |
| idx_i | input | 19 | Target index |
| cam_o | output | 23 | Packed target identification |
| irq_o | output | 1 | Exception request |

## Verification
The bench goes after several corner cases:
- **Privilege boundary.** It reads and writes across pages. A design with the privilege comparison inverted, or off by one ring, would leak hypervisor state to the user page or would accept writes that must be dropped.
- **Misalignment.** It issues misaligned reads and writes of each size. A design that masked the low address bits instead of rejecting the access would return real data instead of all ones, or would corrupt neighbouring bytes.
- **Priority values.** It writes the current-priority byte with 0x07, 0x08, 0xFE and 0xFF, both alone and inside wide writes. A design with a wrong clamp boundary would store an unimplemented priority.
- **Exception compare.** It sets the best pending priority equal to the current priority. A design that used <= would raise a spurious exception there.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int PEND_OFS = 0;
  localparam int CPPR_OFS = 1;
  localparam int NUM_PRIO = 8;
  localparam logic [7:0] PRIO_NONE = 8'hFF;

  // unimplemented priorities collapse to "nothing acceptable"
  function automatic logic [7:0] clamp_prio(input logic [7:0] v);
    return (v < 8'(NUM_PRIO)) ? v : PRIO_NONE;
  endfunction
endpackage

// File: rtl/tctx_decode.sv
module tctx_decode #(
  parameter int RINGS      = 4,
  parameter int RING_BYTES = 16,
  parameter int DATA_BYTES = 8,
  localparam int OFF_W  = $clog2(RINGS * RING_BYTES),
  localparam int PAGE_W = $clog2(RINGS),
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int LEN_W  = $clog2(DATA_BYTES) + 1,
  localparam int SZ_W   = $clog2(LEN_W)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [OFF_W-1:0]  base_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              aligned_o,
  output logic              allowed_o
);
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] ring;
  logic [OFF_W-1:0]  mask;

  assign page   = addr_i[ADDR_W-1 -: PAGE_W];
  assign base_o = addr_i[OFF_W-1:0];
  assign ring   = base_o[OFF_W-1 -: PAGE_W];
  assign len_o  = LEN_W'(1) << size_i;
  assign mask   = ~({OFF_W{1'b1}} << size_i);

  assign aligned_o = (base_o & mask) == '0;
  // higher page number = less privilege = fewer rings
  assign allowed_o = ({1'b0, ring} + {1'b0, page}) <= (PAGE_W+1)'(RINGS - 1);
endmodule

// File: rtl/tctx_prio.sv
module tctx_prio
  import tctx_pkg::*;
(
  input  logic [7:0] pend_i,
  input  logic [7:0] cppr_i,
  output logic       excp_o
);
  logic [7:0] best;

  always_comb begin
    best = PRIO_NONE;
    for (int p = NUM_PRIO - 1; p >= 0; p--) begin
      if (pend_i[p]) best = 8'(p);
    end
  end

  assign excp_o = best < cppr_i;
endmodule

// File: rtl/tctx_window.sv
module tctx_window
  import tctx_pkg::*;
#(
  parameter int RINGS      = 4,
  parameter int RING_BYTES = 16,
  parameter int DATA_BYTES = 8,
  parameter int BLK_W      = 4,
  parameter int IDX_W      = 19,
  localparam int CTX_BYTES = RINGS * RING_BYTES,
  localparam int OFF_W     = $clog2(CTX_BYTES),
  localparam int PAGE_W    = $clog2(RINGS),
  localparam int ADDR_W    = PAGE_W + OFF_W,
  localparam int LEN_W     = $clog2(DATA_BYTES) + 1,
  localparam int SZ_W      = $clog2(LEN_W),
  localparam int DW        = 8 * DATA_BYTES,
  localparam int CAM_W     = BLK_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CAM_W-1:0]  cam_o,
  output logic              irq_o
);
  localparam int KW   = $clog2(DATA_BYTES);
  localparam int RB_W = $clog2(RING_BYTES);

  function automatic logic [CTX_BYTES-1:0][7:0] rst_img();
    logic [CTX_BYTES-1:0][7:0] v;
    v = '0;
    for (int r = 0; r < RINGS; r++) v[r*RING_BYTES+CPPR_OFS] = PRIO_NONE;
    return v;
  endfunction
  localparam logic [CTX_BYTES-1:0][7:0] RST_VAL = rst_img();

  logic [CTX_BYTES-1:0][7:0]  ctx_q, ctx_d;
  logic [DATA_BYTES-1:0][7:0] wbytes, rbytes;
  logic [OFF_W-1:0] base, widx;
  logic [LEN_W-1:0] len;
  logic             aligned, allowed, wr_en;
  logic [RINGS-1:0] excp, pend_any;

  tctx_decode #(
    .RINGS(RINGS), .RING_BYTES(RING_BYTES), .DATA_BYTES(DATA_BYTES)
  ) u_dec (
    .addr_i(addr_i), .size_i(size_i), .base_o(base), .len_o(len),
    .aligned_o(aligned), .allowed_o(allowed)
  );

  assign wbytes = wdata_i;
  assign wr_en  = req_i & we_i & aligned & allowed;

  always_comb begin
    ctx_d = ctx_q;
    widx  = '0;
    if (wr_en) begin
      for (int k = 0; k < DATA_BYTES; k++) begin
        if (k < int'(len)) begin
          widx = base + OFF_W'(k);
          ctx_d[widx] = (widx[RB_W-1:0] == RB_W'(CPPR_OFS)) ?
                        clamp_prio(wbytes[k[KW-1:0]]) : wbytes[k[KW-1:0]];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctx_q <= RST_VAL;
    else         ctx_q <= ctx_d;
  end

  always_comb begin
    rbytes = '0;
    if (req_i && !we_i) begin
      if (!aligned) rbytes = '1;
      else if (allowed) begin
        for (int k = 0; k < DATA_BYTES; k++) begin
          if (k < int'(len)) rbytes[k[KW-1:0]] = ctx_q[base + OFF_W'(k)];
        end
      end
    end
  end
  assign rdata_o = rbytes;

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    tctx_prio u_prio (
      .pend_i(ctx_q[r*RING_BYTES+PEND_OFS]),
      .cppr_i(ctx_q[r*RING_BYTES+CPPR_OFS]),
      .excp_o(excp[r])
    );
    assign pend_any[r] = |ctx_q[r*RING_BYTES+PEND_OFS];

    // R7
    cppr_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctx_q[r*RING_BYTES+CPPR_OFS] < 8'(NUM_PRIO)) ||
      (ctx_q[r*RING_BYTES+CPPR_OFS] == PRIO_NONE));
  end

  assign irq_o = |excp;
  assign cam_o = {blk_i, idx_i};

  // R4
  deny_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && aligned && !allowed) |=> $stable(ctx_q));
  // R6
  misalign_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !aligned) |=> $stable(ctx_q));
  // R6
  misalign_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !aligned) |-> (rdata_o == '1));
  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_any != '0));
endmodule

// File: tb/tctx_window_tb.sv
module tctx_window_tb;
  localparam int CTX = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [63:0] wdata = '0, rdata;
  logic [3:0]  blk = '0;
  logic [18:0] idx = '0;
  logic [22:0] cam;
  logic        irq;

  logic [7:0] m [CTX];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tctx_window u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .blk_i(blk),
    .idx_i(idx), .cam_o(cam), .irq_o(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ad(int p, int r, int b);
    return {2'(p), 2'(r), 4'(b)};
  endfunction

  function automatic bit reach(int page, int ring);
    return ring + page <= 3;
  endfunction

  function automatic logic [63:0] exp_rd(logic [7:0] a, logic [1:0] s);
    int page = int'(a[7:6]);
    int off  = int'(a[5:0]);
    int len  = 1 << s;
    logic [63:0] v = '0;
    if (off % len != 0) return '1;
    if (!reach(page, off / 16)) return '0;
    for (int k = 0; k < len; k++) v[8*k +: 8] = m[off+k];
    return v;
  endfunction

  function automatic void mdl_wr(logic [7:0] a, logic [1:0] s, logic [63:0] d);
    int page = int'(a[7:6]);
    int off  = int'(a[5:0]);
    int len  = 1 << s;
    logic [7:0] b;
    if (off % len != 0 || !reach(page, off / 16)) return;
    for (int k = 0; k < len; k++) begin
      b = d[8*k +: 8];
      if ((off + k) % 16 == 1 && b >= 8'h08 && b != 8'hFF) b = 8'hFF;
      m[off+k] = b;
    end
  endfunction

  function automatic logic exp_irq();
    for (int r = 0; r < 4; r++) begin
      int best = 255;
      for (int p = 7; p >= 0; p--) if (m[r*16][p]) best = p;
      if (best < int'(m[r*16+1])) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic op(bit w, logic [7:0] a, logic [1:0] s, logic [63:0] d, string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    #1;
    if (!w) chk(tag, rdata, exp_rd(a, s));
    @(posedge clk);
    if (w) mdl_wr(a, s, d);
    #1 req = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R9 irq", 64'(irq), 64'(exp_irq()));
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < CTX; b++) m[b] = (b % 16 == 1) ? 8'hFF : 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R5 idle rdata", rdata, 64'h0);
    for (int r = 0; r < 4; r++) begin
      op(1'b0, ad(0, r, 0), 2'd3, '0, "R1");
      op(1'b0, ad(0, r, 8), 2'd3, '0, "R1");
    end

    // R2 layout: write via page 0, read via page 1
    op(1'b1, ad(0, 2, 5), 2'd0, 64'hA5, "R2");
    op(1'b0, ad(1, 2, 5), 2'd0, '0, "R2");
    op(1'b0, ad(1, 2, 4), 2'd1, '0, "R2");
    chk("R2 literal", rdata, 64'h0);
    // R3 / R4 privilege
    op(1'b1, ad(0, 1, 8), 2'd3, 64'h1122334455667788, "R3");
    op(1'b0, ad(3, 1, 8), 2'd3, '0, "R3");
    op(1'b0, ad(2, 1, 8), 2'd3, '0, "R3");
    op(1'b1, ad(2, 3, 4), 2'd2, 64'hDEADBEEF, "R4");
    op(1'b0, ad(0, 3, 4), 2'd2, '0, "R4");
    op(1'b0, ad(3, 0, 0), 2'd3, '0, "R3");
    // R6 misaligned
    op(1'b0, ad(0, 1, 9), 2'd1, '0, "R6");
    op(1'b0, ad(0, 1, 12), 2'd3, '0, "R6");
    op(1'b1, ad(0, 1, 10), 2'd2, 64'hFFFF_FFFF, "R6");
    op(1'b0, ad(0, 1, 8), 2'd3, '0, "R6");
    // R7 clamp boundaries
    op(1'b1, ad(0, 1, 1), 2'd0, 64'h07, "R7");
    op(1'b0, ad(0, 1, 1), 2'd0, '0, "R7");
    op(1'b1, ad(0, 1, 1), 2'd0, 64'h08, "R7");
    op(1'b0, ad(0, 1, 1), 2'd0, '0, "R7");
    op(1'b1, ad(0, 1, 1), 2'd0, 64'hFE, "R7");
    op(1'b0, ad(0, 1, 1), 2'd0, '0, "R7");
    op(1'b1, ad(0, 0, 0), 2'd3, 64'h0000_0000_0000_2000, "R7");
    op(1'b0, ad(0, 0, 0), 2'd1, '0, "R7");
    // R8 / R9 priority compare on ring 2
    op(1'b1, ad(0, 2, 1), 2'd0, 64'h03, "R8");
    op(1'b1, ad(0, 2, 0), 2'd0, 64'h10, "R8");
    chk("R8 best4 vs cppr3", 64'(irq), 64'h0);
    op(1'b1, ad(0, 2, 0), 2'd0, 64'h14, "R8");
    chk("R8 best2 vs cppr3", 64'(irq), 64'h1);
    op(1'b1, ad(0, 2, 1), 2'd0, 64'h02, "R9");
    chk("R9 equal no irq", 64'(irq), 64'h0);
    op(1'b1, ad(0, 2, 0), 2'd1, 64'h0501, "R9");
    chk("R9 wide write", 64'(irq), 64'h1);
    op(1'b1, ad(0, 2, 0), 2'd1, 64'hFF00, "R9");
    // R10
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      blk = 4'($urandom); idx = 19'($urandom);
      #1 chk("R10", 64'(cam), 64'((23'(blk) << 19) | 23'(idx)));
    end
    // random mix
    for (int i = 0; i < 600; i++) begin
      int p = int'($urandom % 4), r = int'($urandom % 4), b;
      logic [1:0] s = 2'($urandom % 4);
      logic [63:0] d = {$urandom, $urandom};
      bit w = 1'($urandom % 2);
      string tag;
      b = ($urandom % 2 == 1) ? int'($urandom % 2) : int'($urandom % 16);
      if (s == 2'd0 && b == 1) d[7:0] = 8'($urandom % 12);
      if (s != 2'd0 && $urandom % 2 == 1) d[15:8] = 8'($urandom % 10);
      if (b % (1 << s) != 0) tag = "R6 rand";
      else if (!reach(p, r)) tag = "R4 rand";
      else tag = "R5 rand";
      op(w, ad(p, r, b), s, d, tag);
      if (w) op(1'b0, ad(0, r, b & ~((1 << s) - 1)), s, '0, "R5 readback");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule